// File: doc/BRIEF.md
# Buffer Descriptor Ring Manager

This block keeps a table of two-word buffer descriptors that a host and two frame-side engines share. A programmable count splits the table: the first entries form the transmit ring and every entry after them forms the receive ring. The host fills and inspects descriptors through a 32-bit register-style bus. Word 0 of each descriptor carries the length, the control bits and the status bits. Word 1 carries the buffer address.

The transmit engine offers the sender the descriptor at its pointer as long as that descriptor's ready bit is set. When the sender reports completion, the engine writes the status back into the descriptor and moves the pointer on. The receive engine works the same way for the receiver: it offers the descriptor at its pointer while the empty bit is set. On completion it stores the frame length and the error flags. Each completion can raise a one-cycle event, selected by the descriptor's interrupt bit. A frame that arrives when no receive descriptor is free raises a busy event instead.

Top module: `bd_ring_mgr`

## Requirements
- R1: After reset:
  - the transmit count reads 64;
  - the transmit pointer is 0 and the receive pointer is 64;
  - every descriptor word reads 0;
  - no event output is high.
- R2: The transmit count register sits at byte address 0x000.
  - A written value above 128 is stored as 128.
  - Every write to it sets the transmit pointer to 0 and the receive pointer to the new count.
- R3: The table begins at byte address 0x400. Word 0 of descriptor n is at 0x400+8n and word 1 is at 0x404+8n. A host read returns its data one clock after the read strobe.
- R4: `tx_avail` is high when the transmit count is non-zero and bit 15 (ready) of word 0 at the transmit pointer is set. While it is high, the outputs present that descriptor:
  - `tx_len` shows word 0 bits 31:16;
  - `tx_buf_addr` shows word 1;
  - `tx_crc_en` shows bit 11;
  - `tx_pad_en` shows bit 12.
- R5: A `tx_done` pulse while `tx_avail` is low changes no descriptor, leaves the pointer where it is and raises no event.
- R6: A `tx_done` pulse while `tx_avail` is high has these effects on word 0 of the current descriptor:
  - bit 15 is cleared;
  - bits 8:0 take `tx_status` (bit 0 carrier lost, bit 1 defer, bit 2 late collision, bit 3 retry limit, bits 7:4 retry count, bit 8 underrun);
  - all other bits keep their values.
  The transmit pointer then advances.
- R7: After the transmit pointer services a descriptor that has bit 13 (wrap) set, it returns to 0. It also returns to 0 after the last transmit entry (count-1).
- R8: Receive behaviour:
  - `rx_avail` is high when the count is below 128 and bit 15 (empty) of word 0 at the receive pointer is set. `rx_buf_addr` shows that descriptor's word 1.
  - On `rx_done`, word 0 becomes {`rx_len`, 0, old bits 14:9, `rx_flags`}. The flags are: bit 0 late collision, 1 CRC error, 2 short, 3 too long, 4 dribble, 5 invalid symbol, 6 overrun, 7 miss, 8 control frame.
  - After the receive pointer services a descriptor with bit 13 set, or entry 127, it returns to the transmit count.
- R9: An `rx_done` pulse while `rx_avail` is low has these effects:
  - `ev_busy` goes high for the following cycle;
  - no descriptor is written;
  - the receive pointer does not move.
- R10: In the cycle after a serviced completion, events fire only if bit 14 (interrupt) of the serviced descriptor is set. In that case exactly one event goes high:
  - transmit: `ev_tx_err` if any of status bits 3:0 or bit 8 is set, otherwise `ev_tx_ok`;
  - receive: `ev_rx_err` if any of flag bits 7:0 is set, otherwise `ev_rx_ok`.
  A set control-frame flag (bit 8) on its own therefore counts as success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_addr | input | 11 | Host byte address |
| hst_we | input | 1 | Host write strobe |
| hst_re | input | 1 | Host read strobe |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid one cycle after `hst_re` |
| tx_avail | output | 1 | A ready transmit descriptor is offered |
| tx_idx | output | 7 | Transmit ring pointer |
| tx_buf_addr | output | 32 | Buffer address of the offered transmit descriptor |
| tx_len | output | 16 | Frame length of the offered transmit descriptor |
| tx_crc_en | output | 1 | CRC-append control bit of the offered descriptor |
| tx_pad_en | output | 1 | Short-frame padding control bit of the offered descriptor |
| tx_done | input | 1 | Sender completion pulse |
| tx_status | input | 9 | Transmit completion status |
| rx_avail | output | 1 | An empty receive descriptor is offered |
| rx_idx | output | 7 | Receive ring pointer |
| rx_buf_addr | output | 32 | Buffer address of the offered receive descriptor |
| rx_done | input | 1 | Receiver completion pulse |
| rx_len | input | 16 | Received length including the 4-byte CRC |
| rx_flags | input | 9 | Receive error and type flags |
| ev_tx_ok | output | 1 | Transmit completed without error |
| ev_tx_err | output | 1 | Transmit completed with error |
| ev_rx_ok | output | 1 | Receive completed without error |
| ev_rx_err | output | 1 | Receive completed with error |
| ev_busy | output | 1 | A frame arrived with no empty receive descriptor |

## Verification
The hardest corner to reach is the receive pointer's fall-back from the very last table entry, which carries no wrap bit, to the start of the receive ring. With the default split that would need more than sixty frames. The stimulus instead programs a transmit count of 126, so only entries 126 and 127 remain in the receive ring, and two completions bring the pointer back to 126. The busy event is reached by completing a frame while the descriptor under the pointer has already been consumed and not yet been given back.

// File: rtl/bdr_pkg.sv
package bdr_pkg;
  localparam int OWN_BIT  = 15;
  localparam int IRQ_BIT  = 14;
  localparam int WRAP_BIT = 13;
  localparam int PAD_BIT  = 12;
  localparam int CRC_BIT  = 11;
  localparam int STAT_W   = 9;

  // transmit write-back: keep length and control, drop ownership, insert status
  function automatic logic [31:0] tx_writeback(input logic [31:0] w0, input logic [STAT_W-1:0] st);
    return {w0[31:16], 1'b0, w0[14:9], st};
  endfunction

  // receive write-back: new length, drop ownership, keep control, insert flags
  function automatic logic [31:0] rx_writeback(input logic [31:0] w0, input logic [15:0] len,
                                               input logic [STAT_W-1:0] fl);
    return {len, 1'b0, w0[14:9], fl};
  endfunction

  function automatic logic tx_is_error(input logic [STAT_W-1:0] st);
    return st[8] | (|st[3:0]);
  endfunction

  function automatic logic rx_is_error(input logic [STAT_W-1:0] fl);
    return |fl[7:0];
  endfunction
endpackage

// File: rtl/bdr_table.sv
module bdr_table #(
  parameter int NUM_BD   = 128,
  parameter int ADDR_W   = 11,
  parameter int TBL_BASE = 'h400,
  parameter int DEF_CNT  = 64,
  localparam int IDX_W   = $clog2(NUM_BD),
  localparam int CNT_W   = $clog2(NUM_BD + 1),
  localparam int WORD_W  = IDX_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic              hst_we,
  input  logic              hst_re,
  input  logic [31:0]       hst_wdata,
  output logic [31:0]       hst_rdata,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [CNT_W-1:0]  cnt_next,
  output logic              cnt_load,
  input  logic [IDX_W-1:0]  tx_ptr,
  input  logic [IDX_W-1:0]  rx_ptr,
  output logic [31:0]       tx_w0,
  output logic [31:0]       tx_w1,
  output logic [31:0]       rx_w0,
  output logic [31:0]       rx_w1,
  input  logic              tx_wb_en,
  input  logic [31:0]       tx_wb_data,
  input  logic              rx_wb_en,
  input  logic [31:0]       rx_wb_data
);
  localparam int TBL_END = TBL_BASE + 8 * NUM_BD;

  logic [31:0]       mem [2*NUM_BD];
  logic [ADDR_W-1:0] off;
  logic [WORD_W-1:0] wi;
  logic              in_tbl, is_cnt;

  assign off      = hst_addr - ADDR_W'(TBL_BASE);
  assign wi       = off[WORD_W+1:2];
  assign in_tbl   = (int'(hst_addr) >= TBL_BASE) && (int'(hst_addr) < TBL_END);
  assign is_cnt   = (hst_addr[ADDR_W-1:2] == '0);
  assign cnt_load = hst_we && is_cnt;
  assign cnt_next = (hst_wdata > 32'(NUM_BD)) ? CNT_W'(NUM_BD) : hst_wdata[CNT_W-1:0];

  assign tx_w0 = mem[{tx_ptr, 1'b0}];
  assign tx_w1 = mem[{tx_ptr, 1'b1}];
  assign rx_w0 = mem[{rx_ptr, 1'b0}];
  assign rx_w1 = mem[{rx_ptr, 1'b1}];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 2*NUM_BD; i++) mem[i] <= '0;
      cnt_q     <= CNT_W'(DEF_CNT);
      hst_rdata <= '0;
    end else begin
      if (tx_wb_en) mem[{tx_ptr, 1'b0}] <= tx_wb_data;
      if (rx_wb_en) mem[{rx_ptr, 1'b0}] <= rx_wb_data;
      if (hst_we && in_tbl) mem[wi] <= hst_wdata;   // host wins a same-word collision
      if (cnt_load) cnt_q <= cnt_next;
      if (hst_re) begin
        if (in_tbl)      hst_rdata <= mem[wi];
        else if (is_cnt) hst_rdata <= 32'(cnt_q);
        else             hst_rdata <= '0;
      end
    end
  end
endmodule

// File: rtl/bdr_tx_engine.sv
module bdr_tx_engine
  import bdr_pkg::*;
#(
  parameter int NUM_BD  = 128,
  localparam int IDX_W  = $clog2(NUM_BD),
  localparam int CNT_W  = $clog2(NUM_BD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic              cnt_load,
  input  logic [31:0]       w0,
  input  logic              done,
  input  logic [STAT_W-1:0] status,
  output logic [IDX_W-1:0]  ptr,
  output logic              avail,
  output logic              take,
  output logic              wb_en,
  output logic [31:0]       wb_data,
  output logic              ev_ok,
  output logic              ev_err
);
  function automatic logic [IDX_W-1:0] tx_next(input logic [IDX_W-1:0] p, input logic wrap,
                                               input logic [CNT_W-1:0] cnt);
    if (wrap || ({1'b0, p} == cnt - 1'b1)) return '0;
    return p + 1'b1;
  endfunction

  assign avail   = (cnt_q != '0) && w0[OWN_BIT];
  assign take    = done && avail;
  assign wb_en   = take;
  assign wb_data = tx_writeback(w0, status);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr    <= '0;
      ev_ok  <= 1'b0;
      ev_err <= 1'b0;
    end else begin
      if (cnt_load)  ptr <= '0;
      else if (take) ptr <= tx_next(ptr, w0[WRAP_BIT], cnt_q);
      ev_ok  <= take && w0[IRQ_BIT] && !tx_is_error(status);
      ev_err <= take && w0[IRQ_BIT] &&  tx_is_error(status);
    end
  end
endmodule

// File: rtl/bdr_rx_engine.sv
module bdr_rx_engine
  import bdr_pkg::*;
#(
  parameter int NUM_BD  = 128,
  parameter int DEF_CNT = 64,
  localparam int IDX_W  = $clog2(NUM_BD),
  localparam int CNT_W  = $clog2(NUM_BD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_q,
  input  logic [CNT_W-1:0]  cnt_next,
  input  logic              cnt_load,
  input  logic [31:0]       w0,
  input  logic              done,
  input  logic [15:0]       len,
  input  logic [STAT_W-1:0] flags,
  output logic [IDX_W-1:0]  ptr,
  output logic              avail,
  output logic              take,
  output logic              wb_en,
  output logic [31:0]       wb_data,
  output logic              ev_ok,
  output logic              ev_err,
  output logic              ev_busy
);
  function automatic logic [IDX_W-1:0] rx_next(input logic [IDX_W-1:0] p, input logic wrap,
                                               input logic [CNT_W-1:0] cnt);
    if (wrap || (int'(p) == NUM_BD - 1)) return cnt[IDX_W-1:0];
    return p + 1'b1;
  endfunction

  assign avail   = (int'(cnt_q) < NUM_BD) && w0[OWN_BIT];
  assign take    = done && avail;
  assign wb_en   = take;
  assign wb_data = rx_writeback(w0, len, flags);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr     <= IDX_W'(DEF_CNT);
      ev_ok   <= 1'b0;
      ev_err  <= 1'b0;
      ev_busy <= 1'b0;
    end else begin
      if (cnt_load)  ptr <= cnt_next[IDX_W-1:0];
      else if (take) ptr <= rx_next(ptr, w0[WRAP_BIT], cnt_q);
      ev_ok   <= take && w0[IRQ_BIT] && !rx_is_error(flags);
      ev_err  <= take && w0[IRQ_BIT] &&  rx_is_error(flags);
      ev_busy <= done && !avail;
    end
  end
endmodule

// File: rtl/bd_ring_mgr.sv
module bd_ring_mgr
  import bdr_pkg::*;
#(
  parameter int NUM_BD   = 128,
  parameter int ADDR_W   = 11,
  parameter int TBL_BASE = 'h400,
  parameter int DEF_CNT  = 64,
  localparam int IDX_W   = $clog2(NUM_BD),
  localparam int CNT_W   = $clog2(NUM_BD + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic              hst_we,
  input  logic              hst_re,
  input  logic [31:0]       hst_wdata,
  output logic [31:0]       hst_rdata,
  output logic              tx_avail,
  output logic [IDX_W-1:0]  tx_idx,
  output logic [31:0]       tx_buf_addr,
  output logic [15:0]       tx_len,
  output logic              tx_crc_en,
  output logic              tx_pad_en,
  input  logic              tx_done,
  input  logic [8:0]        tx_status,
  output logic              rx_avail,
  output logic [IDX_W-1:0]  rx_idx,
  output logic [31:0]       rx_buf_addr,
  input  logic              rx_done,
  input  logic [15:0]       rx_len,
  input  logic [8:0]        rx_flags,
  output logic              ev_tx_ok,
  output logic              ev_tx_err,
  output logic              ev_rx_ok,
  output logic              ev_rx_err,
  output logic              ev_busy
);
  logic [CNT_W-1:0] tx_count, count_next;
  logic             count_load;
  logic [31:0]      tx_w0, tx_w1, rx_w0, rx_w1, tx_wb_data, rx_wb_data;
  logic             tx_wb_en, rx_wb_en, tx_take, rx_take;

  bdr_table #(.NUM_BD(NUM_BD), .ADDR_W(ADDR_W), .TBL_BASE(TBL_BASE), .DEF_CNT(DEF_CNT)) u_table (
    .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_we(hst_we), .hst_re(hst_re),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .cnt_q(tx_count), .cnt_next(count_next),
    .cnt_load(count_load), .tx_ptr(tx_idx), .rx_ptr(rx_idx), .tx_w0(tx_w0), .tx_w1(tx_w1),
    .rx_w0(rx_w0), .rx_w1(rx_w1), .tx_wb_en(tx_wb_en), .tx_wb_data(tx_wb_data),
    .rx_wb_en(rx_wb_en), .rx_wb_data(rx_wb_data));

  bdr_tx_engine #(.NUM_BD(NUM_BD)) u_tx (
    .clk(clk), .rst_n(rst_n), .cnt_q(tx_count), .cnt_load(count_load), .w0(tx_w0),
    .done(tx_done), .status(tx_status), .ptr(tx_idx), .avail(tx_avail), .take(tx_take),
    .wb_en(tx_wb_en), .wb_data(tx_wb_data), .ev_ok(ev_tx_ok), .ev_err(ev_tx_err));

  bdr_rx_engine #(.NUM_BD(NUM_BD), .DEF_CNT(DEF_CNT)) u_rx (
    .clk(clk), .rst_n(rst_n), .cnt_q(tx_count), .cnt_next(count_next), .cnt_load(count_load),
    .w0(rx_w0), .done(rx_done), .len(rx_len), .flags(rx_flags), .ptr(rx_idx),
    .avail(rx_avail), .take(rx_take), .wb_en(rx_wb_en), .wb_data(rx_wb_data),
    .ev_ok(ev_rx_ok), .ev_err(ev_rx_err), .ev_busy(ev_busy));

  assign tx_buf_addr = tx_w1;
  assign tx_len      = tx_w0[31:16];
  assign tx_crc_en   = tx_w0[CRC_BIT];
  assign tx_pad_en   = tx_w0[PAD_BIT];
  assign rx_buf_addr = rx_w1;
endmodule

// File: rtl/bdr_checker.sv
module bdr_checker #(
  parameter int NUM_BD  = 128,
  localparam int IDX_W  = $clog2(NUM_BD),
  localparam int CNT_W  = $clog2(NUM_BD + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] tx_count,
  input logic             count_load,
  input logic [IDX_W-1:0] tx_idx,
  input logic [IDX_W-1:0] rx_idx,
  input logic             tx_done,
  input logic             tx_avail,
  input logic             rx_done,
  input logic             rx_avail,
  input logic             ev_tx_ok,
  input logic             ev_tx_err,
  input logic             ev_rx_ok,
  input logic             ev_rx_err,
  input logic             ev_busy
);
  AST_CNT_MAX: assert property (@(posedge clk) disable iff (!rst_n) int'(tx_count) <= NUM_BD); // R2
  AST_CNT_LOAD_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
    count_load |=> (tx_idx == '0) && ((int'(tx_count) == NUM_BD) || ({1'b0, rx_idx} == tx_count))); // R2
  AST_TX_PTR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count != '0) |-> ({1'b0, tx_idx} < tx_count)); // R7
  AST_RX_PTR_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tx_count) < NUM_BD) |-> ({1'b0, rx_idx} >= tx_count)); // R8
  AST_TX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && !tx_avail && !count_load) |=> (tx_idx == $past(tx_idx)) && !ev_tx_ok && !ev_tx_err); // R5
  AST_BUSY_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && !rx_avail) |=> ev_busy && !ev_rx_ok && !ev_rx_err); // R9
  AST_BUSY_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_done && !rx_avail) |=> !ev_busy); // R9
  AST_EV_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ev_tx_ok, ev_tx_err}) && $onehot0({ev_rx_ok, ev_rx_err})); // R10
endmodule

bind bd_ring_mgr bdr_checker #(.NUM_BD(NUM_BD)) u_bdr_checker (
  .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .count_load(count_load), .tx_idx(tx_idx),
  .rx_idx(rx_idx), .tx_done(tx_done), .tx_avail(tx_avail), .rx_done(rx_done),
  .rx_avail(rx_avail), .ev_tx_ok(ev_tx_ok), .ev_tx_err(ev_tx_err), .ev_rx_ok(ev_rx_ok),
  .ev_rx_err(ev_rx_err), .ev_busy(ev_busy));

// File: tb/test_bd_ring_mgr.sv
module test_bd_ring_mgr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] hst_addr = '0;
  logic        hst_we = 1'b0, hst_re = 1'b0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic        tx_avail, tx_crc_en, tx_pad_en;
  logic [6:0]  tx_idx, rx_idx;
  logic [31:0] tx_buf_addr, rx_buf_addr;
  logic [15:0] tx_len;
  logic        tx_done = 1'b0, rx_done = 1'b0;
  logic [8:0]  tx_status = '0, rx_flags = '0;
  logic [15:0] rx_len = '0;
  logic        rx_avail, ev_tx_ok, ev_tx_err, ev_rx_ok, ev_rx_err, ev_busy;

  int errors = 0, checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [1:0]  tev;
  logic [2:0]  rev;
  bit          finished = 0;

  always #5 clk = ~clk;

  bd_ring_mgr i_bd_ring_mgr (
    .clk(clk), .rst_n(rst_n), .hst_addr(hst_addr), .hst_we(hst_we), .hst_re(hst_re),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .tx_avail(tx_avail), .tx_idx(tx_idx),
    .tx_buf_addr(tx_buf_addr), .tx_len(tx_len), .tx_crc_en(tx_crc_en), .tx_pad_en(tx_pad_en),
    .tx_done(tx_done), .tx_status(tx_status), .rx_avail(rx_avail), .rx_idx(rx_idx),
    .rx_buf_addr(rx_buf_addr), .rx_done(rx_done), .rx_len(rx_len), .rx_flags(rx_flags),
    .ev_tx_ok(ev_tx_ok), .ev_tx_err(ev_tx_err), .ev_rx_ok(ev_rx_ok), .ev_rx_err(ev_rx_err),
    .ev_busy(ev_busy));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] bd(input int n);
    return 11'('h400 + 8 * n);
  endfunction

  task automatic wr(input logic [10:0] a, input logic [31:0] d);
    @(negedge clk); hst_addr = a; hst_wdata = d; hst_we = 1'b1;
    @(negedge clk); hst_we = 1'b0;
  endtask

  // driver: issue read, push expectation into scoreboard
  task automatic rd(input logic [10:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); hst_addr = a; hst_re = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); hst_re = 1'b0;
  endtask

  task automatic txc(input logic [8:0] st, output logic [1:0] ev);
    @(negedge clk); tx_done = 1'b1; tx_status = st;
    @(negedge clk); tx_done = 1'b0; ev = {ev_tx_ok, ev_tx_err};
  endtask

  task automatic rxc(input logic [15:0] len, input logic [8:0] fl, output logic [2:0] ev);
    @(negedge clk); rx_done = 1'b1; rx_len = len; rx_flags = fl;
    @(negedge clk); rx_done = 1'b0; ev = {ev_rx_ok, ev_rx_err, ev_busy};
  endtask

  // monitor: pop and compare as read data appears
  initial forever begin
    @(posedge clk);
    if (hst_re) begin
      #1;
      if (exp_q.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), hst_rdata, exp_q.pop_front());
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 tx_idx", 32'(tx_idx), 0);
    chk("R1 rx_idx", 32'(rx_idx), 64);
    chk("R1 avail", {tx_avail, rx_avail}, 0);
    chk("R1 events", {ev_tx_ok, ev_tx_err, ev_rx_ok, ev_rx_err, ev_busy}, 0);
    rd(0, 64, "R1 count");
    rd(bd(5), 0, "R1 descriptor zero");
    // R2 clamp and pointer reload
    wr(0, 200);
    rd(0, 128, "R2 clamp");
    chk("R2 rx_avail at 128", 32'(rx_avail), 0);
    wr(0, 4);
    rd(0, 4, "R2 readback");
    chk("R2 pointers", {25'(rx_idx), tx_idx}, {25'd4, 7'd0});
    // transmit ring
    wr(bd(0), {16'd60, 16'hD800});
    wr(bd(0) + 4, 32'h1000);
    wr(bd(1), {16'd1500, 16'h8800});
    wr(bd(1) + 4, 32'h2000);
    wr(bd(2), {16'd64, 16'h6000});
    rd(bd(0) + 4, 32'h1000, "R3 word1");
    chk("R4 avail", 32'(tx_avail), 1);
    chk("R4 len", 32'(tx_len), 60);
    chk("R4 addr", tx_buf_addr, 32'h1000);
    chk("R4 crc/pad", {tx_crc_en, tx_pad_en}, 2'b11);
    txc(9'h000, tev);
    chk("R10 tx ok", tev, 2'b10);
    chk("R6 advance", 32'(tx_idx), 1);
    rd(bd(0), {16'd60, 16'h5800}, "R6 writeback clean");
    chk("R4 second desc", {tx_len, 14'd0, tx_crc_en, tx_pad_en}, {16'd1500, 16'h0002});
    chk("R4 second addr", tx_buf_addr, 32'h2000);
    txc(9'h010, tev);
    chk("R10 no irq", tev, 2'b00);
    rd(bd(1), {16'd1500, 16'h0810}, "R6 retry count");
    chk("R5 not ready", {tx_avail, 25'd0, tx_idx}, {1'b0, 25'd0, 7'd2});
    txc(9'h001, tev);
    chk("R5 no event", tev, 2'b00);
    chk("R5 pointer held", 32'(tx_idx), 2);
    rd(bd(2), {16'd64, 16'h6000}, "R5 descriptor unchanged");
    wr(bd(2), {16'd64, 16'hE000});
    txc(9'h004, tev);
    chk("R10 tx err", tev, 2'b01);
    chk("R7 wrap bit", 32'(tx_idx), 0);
    rd(bd(2), {16'd64, 16'h6004}, "R6 late collision");
    for (int i = 0; i < 4; i++) wr(bd(i), {16'd10, 16'h8000});
    for (int i = 0; i < 3; i++) txc(9'h000, tev);
    chk("R7 before end", 32'(tx_idx), 3);
    txc(9'h000, tev);
    chk("R7 end of ring", 32'(tx_idx), 0);
    // receive ring
    wr(bd(4), 32'h0000C000);
    wr(bd(4) + 4, 32'h8000);
    wr(bd(5), 32'h0000E000);
    chk("R8 avail", 32'(rx_avail), 1);
    chk("R8 addr", rx_buf_addr, 32'h8000);
    rxc(16'd100, 9'h000, rev);
    chk("R10 rx ok", rev, 3'b100);
    chk("R8 advance", 32'(rx_idx), 5);
    rd(bd(4), {16'd100, 16'h4000}, "R8 writeback");
    rxc(16'd64, 9'h002, rev);
    chk("R10 rx err", rev, 3'b010);
    chk("R8 wrap", 32'(rx_idx), 4);
    rd(bd(5), {16'd64, 16'h6002}, "R8 crc flag");
    rxc(16'd70, 9'h100, rev);
    chk("R9 busy", rev, 3'b001);
    chk("R9 pointer held", 32'(rx_idx), 4);
    rd(bd(4), {16'd100, 16'h4000}, "R9 no write");
    wr(bd(4), 32'h0000C000);
    rxc(16'd70, 9'h100, rev);
    chk("R10 control frame ok", rev, 3'b100);
    rd(bd(4), {16'd70, 16'h4100}, "R8 control flag");
    // table end fall-back
    wr(0, 126);
    chk("R2 reload", {25'(rx_idx), tx_idx}, {25'd126, 7'd0});
    wr(bd(126), 32'h00008000);
    wr(bd(127), 32'h00008000);
    rxc(16'd20, 9'h000, rev);
    chk("R10 rx no irq", rev, 3'b000);
    rxc(16'd30, 9'h000, rev);
    chk("R8 table end", 32'(rx_idx), 126);
    rd(bd(127), {16'd30, 16'h0000}, "R8 last entry");
    // zero transmit count
    wr(bd(0), {16'd5, 16'hC000});
    wr(0, 0);
    chk("R4 count zero", 32'(tx_avail), 0);
    txc(9'h000, tev);
    chk("R5 count zero event", tev, 2'b00);
    rd(bd(0), {16'd5, 16'hC000}, "R5 count zero untouched");
    repeat (3) @(negedge clk);
    summary();
  end
endmodule